// File: doc/BRIEF.md
# Randomized Root Contention Resolver

This block settles a tie between two neighbouring nodes that have each asked the other to become its parent. One instance sits in each node. When it detects contention, the node stops requesting and sends IDLE. It then uses an internal pseudo-random coin to choose a short or a long backoff window. While it waits, it watches the symbols arriving from the peer. When the wait ends, it either claims the root role by sending ACK, or it asks again to become the child by sending REQ.

A tick enable advances the backoff timer, so the wait is measured in ticks rather than clock cycles. A REQ-or-IDLE symbol from the peer moves the node between two families of wait states. The req-wait states lead to root. The idle-wait states lead to another request. The contention ends in one of two terminal states, almost-root and almost-child. Each has a sticky indication that holds until reset.

The states are contention, received-idle, req-fast, req-slow, idle-fast, idle-slow, sent-req, almost-root and almost-child.

The transitions are:
- contend-to-rxidle
- rxidle-to-contend
- contend-to-reqwait
- rxidle-to-idlewait
- reqwait-to-idlewait
- idlewait-to-reqwait
- reqwait-to-root
- idlewait-to-sentreq
- sentreq-to-child
- sentreq-to-contend

Top module: `rrc_resolver`

## Requirements
- R1: While reset is asserted, the node is in contention, sends IDLE, and drives is_root and is_child low. Reset also loads the coin generator with the SEED parameter (default 16'hACE1).
- R2: In contention, receiving IDLE leads to received-idle; any other symbol clears the timer and leads to req-fast or req-slow according to the coin. In received-idle, receiving REQ leads back to contention; any other symbol clears the timer and leads to idle-fast or idle-slow according to the coin.
- R3: The coin is bit 0 of a 16-bit shift register. Each clock it shifts right and takes bit0^bit2^bit3^bit5 into bit 15. A coin of 1 selects the slow window and 0 selects the fast window.
- R4: The timer counts tick pulses only in the four wait states. It stops at the current window's maximum (85 fast, 167 slow) and never exceeds 168. It is cleared on every entry into a wait state from contention or received-idle.
- R5: In a req-wait state, receiving IDLE moves the node to the idle-wait state of the same speed, and the timer keeps its count. In an idle-wait state, receiving REQ moves it to the req-wait state of the same speed. Other symbols are ignored, and a received symbol takes priority over a timeout in the same cycle.
- R6: A req-wait state whose timer has reached the window minimum (76 fast, 159 slow) moves to almost-root on the next clock.
- R7: An idle-wait state whose timer has reached the window minimum moves to sent-req on the next clock.
- R8: In sent-req, receiving ACK leads to almost-child and receiving REQ leads back to contention. IDLE and no-symbol are ignored.
- R9: Almost-root and almost-child are terminal until reset. is_root is high only in almost-root, is_child only in almost-child, and the two are never high together.
- R10: Symbol codes are NONE=0, IDLE=1, REQ=2, ACK=3. The node sends IDLE in contention, received-idle and all wait states, REQ in sent-req, ACK in almost-root, and NONE in almost-child.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advances the backoff timer by one count |
| rx_sym | input | 2 | Symbol received from the peer |
| tx_sym | output | 2 | Symbol this node sends |
| is_root | output | 1 | Sticky: node won the root role |
| is_child | output | 1 | Sticky: node became the child |

## Verification
The following properties are checked on every cycle:
- The timer never exceeds its window bound.
- The timer is cleared on leaving contention or received-idle.
- A switch between req-wait and idle-wait keeps the count.
- Terminal indications are exclusive and sticky.
- Any entry into root or sent-req happens only after the minimum has been reached.
- Every wait state sends IDLE.

Some behaviour can only be shown by the bench's scenarios, which check it against a model of the coin. These include the exact number of ticks before the decision, and whether the fast or slow window was chosen. They also include the final symbol after a mid-wait change of peer symbol. The return from sent-req to contention followed by a fresh full-length wait is also shown this way.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    typedef enum logic [1:0] {
        SYM_NONE = 2'd0,
        SYM_IDLE = 2'd1,
        SYM_REQ  = 2'd2,
        SYM_ACK  = 2'd3
    } sym_t;

    typedef enum logic [3:0] {
        ST_CONTEND   = 4'd0,
        ST_RXIDLE    = 4'd1,
        ST_REQ_FAST  = 4'd2,
        ST_REQ_SLOW  = 4'd3,
        ST_IDLE_FAST = 4'd4,
        ST_IDLE_SLOW = 4'd5,
        ST_SENT_REQ  = 4'd6,
        ST_ROOT      = 4'd7,
        ST_CHILD     = 4'd8
    } st_t;

endpackage

// File: rtl/rrc_lfsr.sv
module rrc_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'h002D,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    output logic coin
);
    logic [W-1:0] q;
    logic         fb;

    // Feedback is the parity of the tapped bits.
    always_comb fb = ^(q & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {fb, q[W-1:1]};
    end

    always_comb coin = q[0];
endmodule

// File: rtl/rrc_timer.sv
module rrc_timer #(
    parameter int FAST_MAX = 85,
    parameter int SLOW_MAX = 167,
    parameter int SAT      = 168,
    localparam int CW      = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          slow,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] lim;
    logic          inc;

    always_comb begin
        lim = slow ? CW'(SLOW_MAX) : CW'(FAST_MAX);
        inc = run && tick && (cnt < lim) && (cnt < CW'(SAT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/rrc_fsm.sv
module rrc_fsm
    import rrc_pkg::*;
#(
    parameter int FAST_MIN = 76,
    parameter int SLOW_MIN = 159,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sym_t          rx,
    input  logic          coin,
    input  logic [CW-1:0] cnt,
    output st_t           st,
    output logic          clr,
    output logic          run,
    output logic          slow,
    output sym_t          tx,
    output logic          is_root,
    output logic          is_child
);
    st_t  st_nx;
    logic fast_done;
    logic slow_done;

    always_comb begin
        fast_done = (cnt >= CW'(FAST_MIN));
        slow_done = (cnt >= CW'(SLOW_MIN));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_CONTEND;
        else        st <= st_nx;
    end

    // Next state and timer clear
    always_comb begin
        st_nx = st;
        clr   = 1'b0;
        unique case (st)
            ST_CONTEND: begin
                if (rx == SYM_IDLE) st_nx = ST_RXIDLE;
                else begin
                    clr   = 1'b1;
                    st_nx = coin ? ST_REQ_SLOW : ST_REQ_FAST;
                end
            end
            ST_RXIDLE: begin
                if (rx == SYM_REQ) st_nx = ST_CONTEND;
                else begin
                    clr   = 1'b1;
                    st_nx = coin ? ST_IDLE_SLOW : ST_IDLE_FAST;
                end
            end
            ST_REQ_FAST: begin
                if (rx == SYM_IDLE) st_nx = ST_IDLE_FAST;
                else if (fast_done) st_nx = ST_ROOT;
            end
            ST_REQ_SLOW: begin
                if (rx == SYM_IDLE) st_nx = ST_IDLE_SLOW;
                else if (slow_done) st_nx = ST_ROOT;
            end
            ST_IDLE_FAST: begin
                if (rx == SYM_REQ)  st_nx = ST_REQ_FAST;
                else if (fast_done) st_nx = ST_SENT_REQ;
            end
            ST_IDLE_SLOW: begin
                if (rx == SYM_REQ)  st_nx = ST_REQ_SLOW;
                else if (slow_done) st_nx = ST_SENT_REQ;
            end
            ST_SENT_REQ: begin
                if (rx == SYM_ACK)      st_nx = ST_CHILD;
                else if (rx == SYM_REQ) st_nx = ST_CONTEND;
            end
            ST_ROOT:  st_nx = ST_ROOT;
            ST_CHILD: st_nx = ST_CHILD;
            default:  st_nx = ST_CONTEND;
        endcase
    end

    // Outputs
    always_comb begin
        run      = 1'b0;
        slow     = 1'b0;
        tx       = SYM_IDLE;
        is_root  = 1'b0;
        is_child = 1'b0;
        unique case (st)
            ST_CONTEND, ST_RXIDLE: tx = SYM_IDLE;
            ST_REQ_FAST, ST_IDLE_FAST: begin
                run = 1'b1;
                tx  = SYM_IDLE;
            end
            ST_REQ_SLOW, ST_IDLE_SLOW: begin
                run  = 1'b1;
                slow = 1'b1;
                tx   = SYM_IDLE;
            end
            ST_SENT_REQ: tx = SYM_REQ;
            ST_ROOT: begin
                tx      = SYM_ACK;
                is_root = 1'b1;
            end
            ST_CHILD: begin
                tx       = SYM_NONE;
                is_child = 1'b1;
            end
            default: tx = SYM_IDLE;
        endcase
    end
endmodule

// File: rtl/rrc_resolver.sv
module rrc_resolver
    import rrc_pkg::*;
#(
    parameter int          FAST_MIN = 76,
    parameter int          FAST_MAX = 85,
    parameter int          SLOW_MIN = 159,
    parameter int          SLOW_MAX = 167,
    parameter int          TMR_SAT  = 168,
    parameter int          LFSR_W   = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h002D,
    parameter logic [LFSR_W-1:0] SEED      = 16'hACE1,
    localparam int         CW       = $clog2(TMR_SAT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] rx_sym,
    output logic [1:0] tx_sym,
    output logic       is_root,
    output logic       is_child
);
    sym_t          rx_s;
    sym_t          tx_s;
    st_t           st;
    logic          coin;
    logic          clr;
    logic          run;
    logic          slow;
    logic [CW-1:0] tmr_cnt;

    always_comb rx_s   = sym_t'(rx_sym);
    always_comb tx_sym = tx_s;

    rrc_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .SEED (SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .coin  (coin)
    );

    rrc_timer #(
        .FAST_MAX (FAST_MAX),
        .SLOW_MAX (SLOW_MAX),
        .SAT      (TMR_SAT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .run   (run),
        .slow  (slow),
        .tick  (tick),
        .cnt   (tmr_cnt)
    );

    rrc_fsm #(
        .FAST_MIN (FAST_MIN),
        .SLOW_MIN (SLOW_MIN),
        .CW       (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx       (rx_s),
        .coin     (coin),
        .cnt      (tmr_cnt),
        .st       (st),
        .clr      (clr),
        .run      (run),
        .slow     (slow),
        .tx       (tx_s),
        .is_root  (is_root),
        .is_child (is_child)
    );
endmodule

// File: rtl/rrc_resolver_chk.sv
module rrc_resolver_chk
    import rrc_pkg::*;
#(
    parameter int FAST_MIN = 76,
    parameter int FAST_MAX = 85,
    parameter int SLOW_MAX = 167,
    parameter int SAT      = 168,
    parameter int CW       = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    rx_sym,
    input logic [1:0]    tx_sym,
    input logic          is_root,
    input logic          is_child,
    input st_t           st,
    input logic [CW-1:0] cnt
);
    logic in_wait;
    logic in_fast;
    always_comb begin
        in_wait = (st == ST_REQ_FAST) || (st == ST_REQ_SLOW) ||
                  (st == ST_IDLE_FAST) || (st == ST_IDLE_SLOW);
        in_fast = (st == ST_REQ_FAST) || (st == ST_IDLE_FAST);
    end

    // R2: leaving contention or received-idle for a wait state clears the timer
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_CONTEND && rx_sym != 2'd1) || (st == ST_RXIDLE && rx_sym != 2'd2))
        |=> (cnt == '0 && in_wait));

    // R4: timer bounded by the window maximum and saturation
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= CW'(SLOW_MAX)) && (cnt <= CW'(SAT)) && (!in_fast || cnt <= CW'(FAST_MAX)));

    // R5: a req-to-idle switch keeps the count
    a_r5_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REQ_FAST && rx_sym == 2'd1) |=> (st == ST_IDLE_FAST && cnt >= $past(cnt)));

    // R6: root is only claimed after the minimum wait
    a_r6_root_after_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_root) |-> ($past(cnt) >= CW'(FAST_MIN)));

    // R7: a renewed request only after the minimum wait
    a_r7_req_after_min: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_SENT_REQ) ##1 (st == ST_SENT_REQ) |-> ($past(cnt) >= CW'(FAST_MIN)));

    // R9: terminal indications are sticky and exclusive
    a_r9_root_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        is_root |=> is_root);
    a_r9_child_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        is_child |=> is_child);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_root && is_child));

    // R10: wait states send IDLE
    a_r10_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> (tx_sym == 2'd1));
endmodule

bind rrc_resolver rrc_resolver_chk #(
    .FAST_MIN (FAST_MIN),
    .FAST_MAX (FAST_MAX),
    .SLOW_MAX (SLOW_MAX),
    .SAT      (TMR_SAT),
    .CW       (CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_sym   (rx_sym),
    .tx_sym   (tx_sym),
    .is_root  (is_root),
    .is_child (is_child),
    .st       (st),
    .cnt      (tmr_cnt)
);

// File: tb/rrc_resolver_tb.sv
module rrc_resolver_tb;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam int FMIN = 76;
    localparam int SMIN = 159;
    localparam logic [1:0] NONE = 2'd0, IDLE = 2'd1, REQ = 2'd2, ACK = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] rx = 2'd1;
    logic [1:0] tx;
    logic       root;
    logic       child;
    int         errors = 0;
    int         checks = 0;
    logic [15:0] mdl = SEED;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    rrc_resolver u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rx_sym   (rx),
        .tx_sym   (tx),
        .is_root  (root),
        .is_child (child)
    );

    function automatic logic [15:0] lstep(logic [15:0] m);
        return {m[0] ^ m[2] ^ m[3] ^ m[5], m[15:1]};
    endfunction

    function automatic int min_for(bit slow);
        return slow ? SMIN : FMIN;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        mdl = lstep(mdl);
        @(negedge clk);
    endtask

    task automatic do_reset(logic [1:0] first);
        rst_n = 1'b0;
        tick  = 1'b0;
        rx    = first;
        repeat (3) @(negedge clk);
        chk("R1", "reset tx", int'(tx), int'(IDLE));
        chk("R1", "reset root", int'(root), 0);
        chk("R1", "reset child", int'(child), 0);
        rst_n = 1'b1;
        mdl   = SEED;
    endtask

    task automatic tick_n(int k);
        for (int i = 0; i < k; i++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
            step();
        end
    endtask

    task automatic run_until(output int n);
        n = 0;
        while (n < 400) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
            step();
            n++;
            if (tx != IDLE) break;
        end
    endtask

    task automatic run_trial(int t);
        int  nb;
        bit  end_idle;
        bit  do_sw;
        bit  slow;
        bit  in_req;
        int  used;
        int  n;
        nb       = $urandom_range(0, 5);
        end_idle = 1'($urandom_range(0, 1));
        do_sw    = 1'($urandom_range(0, 1));
        do_reset(IDLE);
        for (int i = 0; i < nb; i++) begin
            rx = IDLE;
            step();
            chk("R2", "received-idle tx", int'(tx), int'(IDLE));
            rx = REQ;
            step();
            chk("R2", "back to contention tx", int'(tx), int'(IDLE));
        end
        if (end_idle) begin
            rx = IDLE;
            step();
        end
        slow = mdl[0];
        rx   = NONE;
        step();
        in_req = !end_idle;
        chk("R10", "wait tx", int'(tx), int'(IDLE));
        tick_n(20);
        rx = in_req ? (($urandom_range(0, 1) != 0) ? REQ : ACK)
                    : (($urandom_range(0, 1) != 0) ? IDLE : ACK);
        step();
        rx = NONE;
        chk("R5", "ignored symbol keeps wait", int'(tx), int'(IDLE));
        used = 20;
        if (do_sw) begin
            tick_n(20);
            rx = in_req ? IDLE : REQ;
            step();
            rx = NONE;
            in_req = !in_req;
            used = 40;
            chk("R5", "switch keeps wait", int'(tx), int'(IDLE));
        end
        run_until(n);
        chk(in_req ? "R6" : "R7", "R3 coin window ticks", used + n, min_for(slow));
        chk(in_req ? "R6" : "R7", "decision symbol", int'(tx), int'(in_req ? ACK : REQ));
        if (in_req) begin
            chk("R9", "root flag", int'(root), 1);
            for (int i = 0; i < 8; i++) begin
                rx   = 2'($urandom_range(0, 3));
                tick = 1'($urandom_range(0, 1));
                step();
                chk("R9", "root terminal tx", int'(tx), int'(ACK));
                chk("R9", "root terminal flags", int'({root, child}), 2);
            end
            rx = NONE;
            tick = 1'b0;
        end else begin
            chk("R7", "no flags in sent-req", int'({root, child}), 0);
            rx = IDLE;
            step();
            rx = NONE;
            step();
            chk("R8", "idle ignored in sent-req", int'(tx), int'(REQ));
            if (t % 2 == 0) begin
                rx = ACK;
                step();
                rx = NONE;
                chk("R8", "child flag", int'({root, child}), 1);
                chk("R10", "child tx none", int'(tx), int'(NONE));
                for (int i = 0; i < 8; i++) begin
                    rx   = 2'($urandom_range(0, 3));
                    tick = 1'($urandom_range(0, 1));
                    step();
                    chk("R9", "child terminal flags", int'({root, child}), 1);
                end
                rx = NONE;
                tick = 1'b0;
            end else begin
                rx = REQ;
                step();
                chk("R8", "req returns to contention tx", int'(tx), int'(IDLE));
                chk("R8", "no flags after return", int'({root, child}), 0);
                slow = mdl[0];
                rx   = NONE;
                step();
                run_until(n);
                chk("R4", "timer cleared, full wait", n, min_for(slow));
                chk("R2", "contention leads to root", int'(tx), int'(ACK));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7));
        for (int t = 0; t < 16; t++) run_trial(t);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule